// File: doc/BRIEF.md
# Legacy Display Port Register Front End

This block decodes single-byte host reads and writes in a relocated legacy display I/O window. It sends them to four indexed register banks (sequencer, CRT controller, graphics controller and attribute controller), a miscellaneous output register and a read-only input status register. Every port sits at its legacy address minus 0x300, so the sequencer index port is at offset 0xC4. Each stored byte is also driven out in parallel, so a downstream timing generator can consume the programmed mode without going through the bus.

Most banks use a separate index port and data port. The attribute controller instead shares one write port at offset 0xC0. A two-state machine decides whether the next write there is taken as an index or as data. In state ATTR_INDEX, a write at 0xC0 loads the index and moves to ATTR_DATA. In state ATTR_DATA, a write at 0xC0 stores data at that index and moves back to ATTR_INDEX. A read of the input status port moves either state to ATTR_INDEX. Host software uses that read to put the shared port into a known phase. Bit 7 of CRT register 0x11 write-protects CRT registers 0x00 to 0x07.

Bit 0 of the miscellaneous register selects where the CRT pair and the status port are decoded. When it is 1 they sit at 0xD4/0xD5/0xDA (colour). When it is 0 they sit at 0xB4/0xB5/0xBA (monochrome).

Top module: `vga_regport`

## Requirements
- R1: After reset, every bank register, every index, the miscellaneous register and `bus_rdata` are zero, the attribute phase is ATTR_INDEX, and so the CRT protect bit is 0.
- R2: A write to an index port (sequencer 0xC4, graphics 0xCE) loads that bank's index, and a read of the index port returns it. A write to the data port (0xC5, 0xCF) stores the byte at the current index, and a read of the data port returns the register at the current index.
- R3: The CRT index/data ports sit at 0xD4/0xD5 when miscellaneous bit 0 is 1, and at 0xB4/0xB5 when it is 0. Accesses at the inactive pair have no effect and read as zero.
- R4: Writes at 0xC0 alternate between loading the attribute index (ATTR_INDEX) and storing attribute data at that index (ATTR_DATA). A read of 0xC0 returns the attribute index, and a read of 0xC1 returns the attribute register at that index.
- R5: A read of the input status port (0xDA in colour mode, 0xBA in monochrome mode) returns bit 3 = `vretrace_i` and bit 0 = NOT `display_en_i`, with all other bits 0. The same read forces the attribute phase to ATTR_INDEX.
- R6: While bit 7 of CRT register 0x11 is 1, writes to CRT registers 0x00 to 0x07 are ignored. Writes to higher CRT registers still take effect, and clearing the bit restores access.
- R7: An index at or beyond a bank's size (sequencer 5, graphics 9, attribute 21, CRT 28) reads as zero at the data port, and writes through it change nothing.
- R8: The miscellaneous register is written at 0xC2 and read at 0xCC. Its decoded outputs follow it as follows: colour addressing is bit 0, PLL clock select is set when bits 3:2 are 11, positive horizontal sync is bit 6 and positive vertical sync is bit 7. The vertical interrupt enable output is bit 5 of CRT register 0x11.
- R9: The parallel register outputs show register i of a bank at bits [8i+7:8i], and they reflect a write from the clock edge that accepts it.
- R10: `bus_rdata` is loaded on the clock edge at which `bus_rd` is high, with the value of the addressed port before any same-edge update. It holds its value in cycles without a read. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset inside the relocated window |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| vretrace_i | input | 1 | Vertical retrace flag, visible in the status port |
| display_en_i | input | 1 | Display active flag, inverted in the status port |
| seq_regs_o | output | SEQ_N*8 | Sequencer registers, flattened |
| crtc_regs_o | output | CRTC_N*8 | CRT controller registers, flattened |
| gfx_regs_o | output | GFX_N*8 | Graphics controller registers, flattened |
| attr_regs_o | output | ATTR_N*8 | Attribute controller registers, flattened |
| misc_o | output | 8 | Miscellaneous output register |
| color_addr_o | output | 1 | Colour addressing selected |
| pll_clk_sel_o | output | 1 | PLL clock selected |
| hsync_pos_o | output | 1 | Positive horizontal sync |
| vsync_pos_o | output | 1 | Positive vertical sync |
| vert_int_en_o | output | 1 | Vertical interrupt enable |
| crtc_protect_o | output | 1 | CRT low-register write protect active |

## Verification
The bench aims at four corner cases. The first is the attribute port's phase after a status read that lands between an index write and a data write; a design that ignored that read would store the next index byte as data. The second is a CRT write at indices 0x07 and 0x08 while protection is set; an off-by-one in the range compare would either block register 8 or corrupt register 7. The third is monochrome/colour switching, where stale decoding would respond at the inactive pair. The fourth is out-of-range indices just past each bank's size, which a truncated index compare would alias onto a low register.

// File: rtl/vga_regport_pkg.sv
package vga_regport_pkg;

    localparam int BYTE_W = 8;

    // Offsets inside the relocated window (legacy address minus 0x300)
    localparam int OFS_ATTR_WR  = 'hC0;
    localparam int OFS_ATTR_RD  = 'hC1;
    localparam int OFS_MISC_WR  = 'hC2;
    localparam int OFS_SEQ_IX   = 'hC4;
    localparam int OFS_SEQ_DA   = 'hC5;
    localparam int OFS_MISC_RD  = 'hCC;
    localparam int OFS_GFX_IX   = 'hCE;
    localparam int OFS_GFX_DA   = 'hCF;
    localparam int CRT_BASE_CLR = 'hD0;
    localparam int CRT_BASE_MON = 'hB0;
    localparam int CRT_IX_LO    = 'h4;
    localparam int CRT_DA_LO    = 'h5;
    localparam int STATUS_LO    = 'hA;

    typedef enum logic {
        ATTR_INDEX = 1'b0,
        ATTR_DATA  = 1'b1
    } attr_phase_t;

    typedef struct packed {
        logic attr_wr;
        logic attr_rd;
        logic misc_wr;
        logic misc_rd;
        logic seq_ix;
        logic seq_da;
        logic gfx_ix;
        logic gfx_da;
        logic crt_ix;
        logic crt_da;
        logic status;
    } port_sel_t;

endpackage

// File: rtl/vga_port_decode.sv
module vga_port_decode
    import vga_regport_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              color_i,
    output port_sel_t         sel_o
);
    logic [ADDR_W-1:0] crt_base;

    always_comb begin
        crt_base      = color_i ? ADDR_W'(CRT_BASE_CLR) : ADDR_W'(CRT_BASE_MON);
        sel_o.attr_wr = (addr_i == ADDR_W'(OFS_ATTR_WR));
        sel_o.attr_rd = (addr_i == ADDR_W'(OFS_ATTR_RD));
        sel_o.misc_wr = (addr_i == ADDR_W'(OFS_MISC_WR));
        sel_o.misc_rd = (addr_i == ADDR_W'(OFS_MISC_RD));
        sel_o.seq_ix  = (addr_i == ADDR_W'(OFS_SEQ_IX));
        sel_o.seq_da  = (addr_i == ADDR_W'(OFS_SEQ_DA));
        sel_o.gfx_ix  = (addr_i == ADDR_W'(OFS_GFX_IX));
        sel_o.gfx_da  = (addr_i == ADDR_W'(OFS_GFX_DA));
        sel_o.crt_ix  = (addr_i == (crt_base | ADDR_W'(CRT_IX_LO)));
        sel_o.crt_da  = (addr_i == (crt_base | ADDR_W'(CRT_DA_LO)));
        sel_o.status  = (addr_i == (crt_base | ADDR_W'(STATUS_LO)));
    end
endmodule

// File: rtl/vga_attr_flipflop.sv
module vga_attr_flipflop
    import vga_regport_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        port_wr_i,
    input  logic        clear_i,
    output attr_phase_t phase_o,
    output logic        idx_we_o,
    output logic        data_we_o
);
    attr_phase_t state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ATTR_INDEX;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d   = state_q;
        idx_we_o  = 1'b0;
        data_we_o = 1'b0;
        unique case (state_q)
            ATTR_INDEX: begin
                idx_we_o = port_wr_i;
                if (port_wr_i) state_d = ATTR_DATA;
            end
            ATTR_DATA: begin
                data_we_o = port_wr_i;
                if (port_wr_i) state_d = ATTR_INDEX;
            end
        endcase
        if (clear_i) state_d = ATTR_INDEX;
    end

    assign phase_o = state_q;
endmodule

// File: rtl/vga_reg_bank.sv
module vga_reg_bank #(
    parameter int DEPTH  = 5,
    parameter int IDX_W  = 8,
    parameter int PROT_N = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_we_i,
    input  logic               data_we_i,
    input  logic [7:0]         wdata_i,
    input  logic               protect_i,
    output logic [IDX_W-1:0]   idx_o,
    output logic [7:0]         rd_o,
    output logic [DEPTH*8-1:0] regs_o
);
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       regs_q [DEPTH];
    logic             blocked;

    generate
        if (PROT_N > 0) begin : g_prot
            assign blocked = protect_i && (idx_q < IDX_W'(PROT_N));
        end else begin : g_noprot
            assign blocked = protect_i & 1'b0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
        end else begin
            if (idx_we_i) idx_q <= wdata_i[IDX_W-1:0];
            for (int i = 0; i < DEPTH; i++) begin
                if (data_we_i && !blocked && idx_q == IDX_W'(i)) regs_q[i] <= wdata_i;
            end
        end
    end

    always_comb begin
        rd_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (idx_q == IDX_W'(i)) rd_o = regs_q[i];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign regs_o[g*8 +: 8] = regs_q[g];
        end
    endgenerate

    assign idx_o = idx_q;
endmodule

// File: rtl/vga_regport.sv
module vga_regport
    import vga_regport_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SEQ_N    = 5,
    parameter int CRTC_N   = 28,
    parameter int GFX_N    = 9,
    parameter int ATTR_N   = 21,
    parameter int PROT_N   = 8,
    parameter int PROT_REG = 17
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                vretrace_i,
    input  logic                display_en_i,
    output logic [SEQ_N*8-1:0]  seq_regs_o,
    output logic [CRTC_N*8-1:0] crtc_regs_o,
    output logic [GFX_N*8-1:0]  gfx_regs_o,
    output logic [ATTR_N*8-1:0] attr_regs_o,
    output logic [7:0]          misc_o,
    output logic                color_addr_o,
    output logic                pll_clk_sel_o,
    output logic                hsync_pos_o,
    output logic                vsync_pos_o,
    output logic                vert_int_en_o,
    output logic                crtc_protect_o
);
    localparam int IDX_W    = BYTE_W;
    localparam int PROT_BIT = PROT_REG * 8 + 7;
    localparam int VINT_BIT = PROT_REG * 8 + 5;

    port_sel_t   sel;
    attr_phase_t attr_phase;
    logic        attr_idx_we, attr_data_we;
    logic [7:0]  misc_q;
    logic [IDX_W-1:0] seq_idx, gfx_idx, crtc_idx, attr_idx;
    logic [7:0]  seq_rd, gfx_rd, crtc_rd, attr_rd;
    logic [7:0]  status_val, rd_next;

    vga_port_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i (bus_addr),
        .color_i(misc_q[0]),
        .sel_o  (sel)
    );

    vga_attr_flipflop u_attr_ff (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_wr_i(bus_wr && sel.attr_wr),
        .clear_i  (bus_rd && sel.status),
        .phase_o  (attr_phase),
        .idx_we_o (attr_idx_we),
        .data_we_o(attr_data_we)
    );

    vga_reg_bank #(.DEPTH(SEQ_N), .IDX_W(IDX_W), .PROT_N(0)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .idx_we_i(bus_wr && sel.seq_ix), .data_we_i(bus_wr && sel.seq_da),
        .wdata_i(bus_wdata), .protect_i(1'b0),
        .idx_o(seq_idx), .rd_o(seq_rd), .regs_o(seq_regs_o)
    );

    vga_reg_bank #(.DEPTH(CRTC_N), .IDX_W(IDX_W), .PROT_N(PROT_N)) u_crtc (
        .clk(clk), .rst_n(rst_n),
        .idx_we_i(bus_wr && sel.crt_ix), .data_we_i(bus_wr && sel.crt_da),
        .wdata_i(bus_wdata), .protect_i(crtc_protect_o),
        .idx_o(crtc_idx), .rd_o(crtc_rd), .regs_o(crtc_regs_o)
    );

    vga_reg_bank #(.DEPTH(GFX_N), .IDX_W(IDX_W), .PROT_N(0)) u_gfx (
        .clk(clk), .rst_n(rst_n),
        .idx_we_i(bus_wr && sel.gfx_ix), .data_we_i(bus_wr && sel.gfx_da),
        .wdata_i(bus_wdata), .protect_i(1'b0),
        .idx_o(gfx_idx), .rd_o(gfx_rd), .regs_o(gfx_regs_o)
    );

    vga_reg_bank #(.DEPTH(ATTR_N), .IDX_W(IDX_W), .PROT_N(0)) u_attr (
        .clk(clk), .rst_n(rst_n),
        .idx_we_i(attr_idx_we), .data_we_i(attr_data_we),
        .wdata_i(bus_wdata), .protect_i(1'b0),
        .idx_o(attr_idx), .rd_o(attr_rd), .regs_o(attr_regs_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                    misc_q <= '0;
        else if (bus_wr && sel.misc_wr) misc_q <= bus_wdata;
    end

    assign status_val = {4'b0000, vretrace_i, 2'b00, ~display_en_i};

    always_comb begin
        rd_next = '0;
        if      (sel.attr_wr) rd_next = attr_idx;
        else if (sel.attr_rd) rd_next = attr_rd;
        else if (sel.misc_rd) rd_next = misc_q;
        else if (sel.seq_ix)  rd_next = seq_idx;
        else if (sel.seq_da)  rd_next = seq_rd;
        else if (sel.gfx_ix)  rd_next = gfx_idx;
        else if (sel.gfx_da)  rd_next = gfx_rd;
        else if (sel.crt_ix)  rd_next = crtc_idx;
        else if (sel.crt_da)  rd_next = crtc_rd;
        else if (sel.status)  rd_next = status_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_next;
    end

    assign misc_o         = misc_q;
    assign color_addr_o   = misc_q[0];
    assign pll_clk_sel_o  = &misc_q[3:2];
    assign hsync_pos_o    = misc_q[6];
    assign vsync_pos_o    = misc_q[7];
    assign vert_int_en_o  = crtc_regs_o[VINT_BIT];
    assign crtc_protect_o = crtc_regs_o[PROT_BIT];
endmodule

// File: rtl/vga_regport_checker.sv
module vga_regport_checker #(
    parameter int ADDR_W = 8,
    parameter int SEQ_N  = 5,
    parameter int CRTC_N = 28,
    parameter int PROT_N = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic [7:0]          misc_o,
    input logic [SEQ_N*8-1:0]  seq_regs_o,
    input logic [CRTC_N*8-1:0] crtc_regs_o,
    input logic                crtc_protect_o,
    input logic                attr_phase,
    input logic [7:0]          seq_idx,
    input logic [7:0]          crtc_idx
);
    logic [ADDR_W-1:0] crt_da_addr, status_addr;
    assign crt_da_addr = misc_o[0] ? ADDR_W'('hD5) : ADDR_W'('hB5);
    assign status_addr = misc_o[0] ? ADDR_W'('hDA) : ADDR_W'('hBA);

    assert_attr_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'('hC0) |=> attr_phase != $past(attr_phase));

    assert_status_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd && bus_addr == status_addr |=> attr_phase == 1'b0);

    assert_low_crtc_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == crt_da_addr && crtc_protect_o && crtc_idx < 8'(PROT_N)
        |=> $stable(crtc_regs_o[PROT_N*8-1:0]));

    assert_seq_oob_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'('hC5) && seq_idx >= 8'(SEQ_N) |=> $stable(seq_regs_o));

    assert_misc_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == ADDR_W'('hC2) |=> misc_o == $past(bus_wdata));

    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

bind vga_regport vga_regport_checker #(
    .ADDR_W(ADDR_W), .SEQ_N(SEQ_N), .CRTC_N(CRTC_N), .PROT_N(PROT_N)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .misc_o(misc_o),
    .seq_regs_o(seq_regs_o), .crtc_regs_o(crtc_regs_o), .crtc_protect_o(crtc_protect_o),
    .attr_phase(attr_phase), .seq_idx(seq_idx), .crtc_idx(crtc_idx)
);

// File: tb/vga_regport_bench.sv
module vga_regport_bench;
    localparam int NS = 5, NC = 28, NG = 9, NA = 21;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] bus_addr = '0, bus_wdata = '0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic vretrace_i = 1'b0, display_en_i = 1'b1;
    logic [7:0] bus_rdata, misc_o;
    logic [NS*8-1:0] seq_regs_o;
    logic [NC*8-1:0] crtc_regs_o;
    logic [NG*8-1:0] gfx_regs_o;
    logic [NA*8-1:0] attr_regs_o;
    logic color_addr_o, pll_clk_sel_o, hsync_pos_o, vsync_pos_o, vert_int_en_o, crtc_protect_o;

    always #2 clk = ~clk;

    vga_regport u_vga_regport (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .vretrace_i(vretrace_i),
        .display_en_i(display_en_i), .seq_regs_o(seq_regs_o), .crtc_regs_o(crtc_regs_o),
        .gfx_regs_o(gfx_regs_o), .attr_regs_o(attr_regs_o), .misc_o(misc_o),
        .color_addr_o(color_addr_o), .pll_clk_sel_o(pll_clk_sel_o), .hsync_pos_o(hsync_pos_o),
        .vsync_pos_o(vsync_pos_o), .vert_int_en_o(vert_int_en_o), .crtc_protect_o(crtc_protect_o)
    );

    int checks = 0, errors = 0;
    logic [7:0] m_seq [NS];
    logic [7:0] m_crt [NC];
    logic [7:0] m_gfx [NG];
    logic [7:0] m_att [NA];
    logic [7:0] m_sx, m_cx, m_gx, m_ax, m_misc;
    logic m_tog;

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] base_of();
        return m_misc[0] ? 8'hD0 : 8'hB0;
    endfunction

    function automatic logic [7:0] model_read(input logic [7:0] a);
        logic [7:0] b = base_of();
        if (a == 8'hC0) return m_ax;
        if (a == 8'hC1) return (m_ax < NA) ? m_att[m_ax] : 8'h00;
        if (a == 8'hCC) return m_misc;
        if (a == 8'hC4) return m_sx;
        if (a == 8'hC5) return (m_sx < NS) ? m_seq[m_sx] : 8'h00;
        if (a == 8'hCE) return m_gx;
        if (a == 8'hCF) return (m_gx < NG) ? m_gfx[m_gx] : 8'h00;
        if (a == (b | 8'h04)) return m_cx;
        if (a == (b | 8'h05)) return (m_cx < NC) ? m_crt[m_cx] : 8'h00;
        if (a == (b | 8'h0A)) return {4'b0, vretrace_i, 2'b00, ~display_en_i};
        return 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        logic [7:0] b = base_of();
        if (a == 8'hC0) begin
            if (!m_tog) m_ax = d;
            else if (m_ax < NA) m_att[m_ax] = d;
            m_tog = ~m_tog;
        end
        else if (a == 8'hC2) m_misc = d;
        else if (a == 8'hC4) m_sx = d;
        else if (a == 8'hC5) begin if (m_sx < NS) m_seq[m_sx] = d; end
        else if (a == 8'hCE) m_gx = d;
        else if (a == 8'hCF) begin if (m_gx < NG) m_gfx[m_gx] = d; end
        else if (a == (b | 8'h04)) m_cx = d;
        else if (a == (b | 8'h05)) begin
            if (m_cx < NC && !(m_crt[17][7] && m_cx < 8)) m_crt[m_cx] = d;
        end
    endtask

    task automatic check_outputs(input string req);
        logic [NS*8-1:0] es; logic [NC*8-1:0] ec; logic [NG*8-1:0] eg; logic [NA*8-1:0] ea;
        for (int i = 0; i < NS; i++) es[i*8 +: 8] = m_seq[i];
        for (int i = 0; i < NC; i++) ec[i*8 +: 8] = m_crt[i];
        for (int i = 0; i < NG; i++) eg[i*8 +: 8] = m_gfx[i];
        for (int i = 0; i < NA; i++) ea[i*8 +: 8] = m_att[i];
        check({req, " R9 seq"}, 256'(seq_regs_o), 256'(es));
        check({req, " R9 crtc"}, 256'(crtc_regs_o), 256'(ec));
        check({req, " R9 gfx"}, 256'(gfx_regs_o), 256'(eg));
        check({req, " R9 attr"}, 256'(attr_regs_o), 256'(ea));
        check({req, " R8 misc"},
              256'({misc_o, color_addr_o, pll_clk_sel_o, hsync_pos_o, vsync_pos_o, vert_int_en_o, crtc_protect_o}),
              256'({m_misc, m_misc[0], &m_misc[3:2], m_misc[6], m_misc[7], m_crt[17][5], m_crt[17][7]}));
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        check_outputs(req);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [7:0] exp;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        exp = model_read(a);
        @(negedge clk);
        bus_rd = 1'b0;
        check({req, " R10 rdata"}, 256'(bus_rdata), 256'(exp));
        if (a == (base_of() | 8'h0A)) m_tog = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] ports [14] = '{8'hC0, 8'hC1, 8'hC2, 8'hC4, 8'hC5, 8'hCC, 8'hCE,
                                   8'hCF, 8'hD4, 8'hD5, 8'hDA, 8'hB4, 8'hB5, 8'hBA};
        void'($urandom(32'd1234));
        for (int i = 0; i < NS; i++) m_seq[i] = '0;
        for (int i = 0; i < NC; i++) m_crt[i] = '0;
        for (int i = 0; i < NG; i++) m_gfx[i] = '0;
        for (int i = 0; i < NA; i++) m_att[i] = '0;
        m_sx = 0; m_cx = 0; m_gx = 0; m_ax = 0; m_misc = 0; m_tog = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_outputs("R1 reset");
        check("R1 rdata", 256'(bus_rdata), 256'(0));
        rd(8'hC0, "R1 attr index");
        // R2 sequencer / graphics
        wr(8'hC4, 8'h02, "R2"); wr(8'hC5, 8'h5A, "R2");
        rd(8'hC4, "R2 seq index"); rd(8'hC5, "R2 seq data");
        wr(8'hCE, 8'h08, "R2"); wr(8'hCF, 8'hC3, "R2"); rd(8'hCF, "R2 gfx data");
        // R3 mono then colour addressing
        wr(8'hB4, 8'h0A, "R3 mono"); wr(8'hB5, 8'h11, "R3 mono"); rd(8'hB5, "R3 mono read");
        rd(8'hD5, "R3 inactive colour pair");
        wr(8'hC2, 8'hCD, "R8 misc"); rd(8'hCC, "R8 misc read");
        wr(8'hB5, 8'h77, "R3 inactive write"); rd(8'hB5, "R3 inactive read");
        wr(8'hD4, 8'h1B, "R3"); wr(8'hD5, 8'h9E, "R3"); rd(8'hD5, "R3 colour read");
        // R6 protection
        wr(8'hD4, 8'h11, "R6"); wr(8'hD5, 8'hA0, "R6 set protect + vint");
        wr(8'hD4, 8'h07, "R6"); wr(8'hD5, 8'h55, "R6 blocked idx7"); rd(8'hD5, "R6 blocked read");
        wr(8'hD4, 8'h08, "R6"); wr(8'hD5, 8'h66, "R6 idx8 open"); rd(8'hD5, "R6 idx8 read");
        wr(8'hD4, 8'h11, "R6"); wr(8'hD5, 8'h00, "R6 clear protect");
        wr(8'hD4, 8'h00, "R6"); wr(8'hD5, 8'h44, "R6 reopened"); rd(8'hD5, "R6 reopened read");
        // R4 / R5 attribute toggle
        wr(8'hC0, 8'h10, "R4 index"); wr(8'hC0, 8'h41, "R4 data");
        rd(8'hC1, "R4 data read"); rd(8'hC0, "R4 index read");
        wr(8'hC0, 8'h05, "R4 index"); rd(8'hDA, "R5 status clears toggle");
        wr(8'hC0, 8'h07, "R5 index after clear"); rd(8'hC0, "R5 index read");
        wr(8'hC0, 8'h3C, "R5 data"); rd(8'hC1, "R5 data read");
        vretrace_i = 1'b1; display_en_i = 1'b0; rd(8'hDA, "R5 status bits");
        // R7 out of range
        wr(8'hC4, 8'h05, "R7"); wr(8'hC5, 8'hFF, "R7 seq oob"); rd(8'hC5, "R7 seq oob read");
        wr(8'hCE, 8'h09, "R7"); wr(8'hCF, 8'hFF, "R7 gfx oob"); rd(8'hCF, "R7 gfx oob read");
        wr(8'hD4, 8'h1C, "R7"); wr(8'hD5, 8'hFF, "R7 crtc oob"); rd(8'hD5, "R7 crtc oob read");
        wr(8'hC0, 8'h15, "R7"); wr(8'hC0, 8'hFF, "R7 attr oob"); rd(8'hC1, "R7 attr oob read");
        rd(8'h10, "R10 unmapped");
        // Constrained random mix
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] a, d;
            a = ports[$urandom_range(13, 0)];
            d = ($urandom_range(3, 0) == 0) ? 8'($urandom) : 8'($urandom_range(31, 0));
            vretrace_i = 1'($urandom); display_en_i = 1'($urandom);
            if ($urandom_range(1, 0) == 1) wr(a, d, "R2-rand");
            else rd(a, "R4-rand");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule